// File: doc/BRIEF.md
# Dual-Channel Cosine Tone Synthesizer

This block makes tones for two 8-bit DAC code outputs by direct digital synthesis. A 16-bit phase accumulator is shared by both channels. It adds a programmable step on every tick of a divided clock. The top byte of the phase addresses a full-period cosine table that holds signed 8-bit samples. Each channel then applies its own settings to the shared sample: an arithmetic right shift that scales the amplitude, a DC offset that adds modulo 256, and one of four bit-inversion modes. The result, or a static code written by software, goes to the channel's output register.

Software sets the block up through a simple write port. One global run bit starts the prescaler and the accumulator. Clearing it stops both and returns the phase to zero, so every run starts on the cosine peak. A channel shows the tone only while the global run bit and its own tone enable are both set. Otherwise it shows its static code. The first time a channel's tone enable is set, the block selects the MSB-only inversion, which turns the signed sample into an unsigned DAC code.

Top module: `dual_tone_dds`

## Requirements
- R1: Synchronous active-high reset drives both outputs and both static codes to 0, clears the run bit, divider, offsets, scales, inversions and tone enables, and sets the step to 1.
- R2: Address 4 (channel 0) and address 5 (channel 1) hold a static code in data[7:0]. A channel whose tone is not active shows its static code on the clock edge after the register updates.
- R3: Address 0 holds the step, data[15:0]. On every tick the output takes the processed value of table entry phase[15:8], and then the phase advances by the step. Entry i is round(127*cos(2*pi*i/256)), rounded half away from zero. After run is set with divider 0, the first sample is entry 0 and appears one clock edge after the write.
- R4: Address 1 holds the divider in data[2:0] and the run bit in data[3]. With run set, a tick occurs every divider+1 clocks, so one tone period lasts (divider+1)*65536/step clocks. Between ticks an active channel's output holds.
- R5: A write of 0 to the step register is ignored, and the previous step stays in effect.
- R6: Channel configuration sits at address 2 (channel 0) and address 3 (channel 1). Scale code data[9:8] shifts the signed sample right arithmetically by 0, 1, 2 or 3 bits.
- R7: The offset in data[7:0] is added to the scaled sample modulo 256, before inversion.
- R8: The inversion code data[11:10] selects: 0 passes the value unchanged, 1 inverts all bits, 2 inverts bit 7 only, 3 inverts bits 6..0 only.
- R9: Tone enable is data[12]. A write that sets it while it is clear stores inversion code 2 whatever data[11:10] holds. A write with tone enable already set stores data[11:10].
- R10: A channel's tone is active only when the run bit and its tone enable are both set. Clearing run resets the phase to 0, so the next run starts again at entry 0.
- R11: A configuration write that lands on a tick edge does not affect the sample taken at that edge. The new setting applies from the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| dac0_code | output | 8 | Channel 0 DAC code |
| dac1_code | output | 8 | Channel 1 DAC code |

## Verification
A register write and a divided-clock tick can land on the same clock edge. With divider 0 every edge is a tick, so every setting change collides with a sample.

The bench writes a new scale code in the middle of a running tone. The sample taken at the write edge must still show the old scale, and the next sample must show the new one. The forced MSB inversion at tone enable is judged in the same way: a later rewrite of the inversion field must take effect one tick after it lands.

// File: rtl/tone_pkg.sv
package tone_pkg;
  // register address width and fixed sample width shared by all submodules
  localparam int ADDR_W   = 3;
  localparam int SAMPLE_W = 8;

  localparam int STEP_ADDR = 0;
  localparam int CTRL_ADDR = 1;
  localparam int CFG_BASE  = 2;
  localparam int CODE_BASE = 4;

  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_ALL  = 2'd1,
    INV_MSB  = 2'd2,
    INV_LOW  = 2'd3
  } inv_mode_e;

  // packed so that bit positions match the configuration write word
  typedef struct packed {
    logic                tone_en;
    inv_mode_e           inv;
    logic [1:0]          scale;
    logic [SAMPLE_W-1:0] offset;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/tone_regs.sv
module tone_regs
  import tone_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int DIV_W   = 3,
  parameter int NUM_CH  = 2,
  parameter int DATA_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [PHASE_W-1:0]  step_q,
  output logic [DIV_W-1:0]    div_q,
  output logic                run_q,
  output chan_cfg_t           cfg_q  [NUM_CH],
  output logic [SAMPLE_W-1:0] code_q [NUM_CH]
);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  // global step, divider and run bit; a zero step is refused
  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= PHASE_W'(1);
      div_q  <= '0;
      run_q  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == STEP_A && wr_data[PHASE_W-1:0] != '0)
        step_q <= wr_data[PHASE_W-1:0];
      if (wr_addr == CTRL_A) begin
        div_q <= wr_data[DIV_W-1:0];
        run_q <= wr_data[DIV_W];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_BASE + c);
    localparam logic [ADDR_W-1:0] CODE_A = ADDR_W'(CODE_BASE + c);
    chan_cfg_t wr_cfg;

    // turning the tone on selects the MSB-only inversion
    always_comb begin
      wr_cfg = chan_cfg_t'(wr_data[CFG_W-1:0]);
      if (wr_cfg.tone_en && !cfg_q[c].tone_en)
        wr_cfg.inv = INV_MSB;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[c]  <= '0;
        code_q[c] <= '0;
      end else if (wr_en) begin
        if (wr_addr == CFG_A)  cfg_q[c]  <= wr_cfg;
        if (wr_addr == CODE_A) code_q[c] <= wr_data[SAMPLE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tone_phase.sv
module tone_phase #(
  parameter int PHASE_W = 16,
  parameter int DIV_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [DIV_W-1:0]   div,
  input  logic [PHASE_W-1:0] step,
  output logic               tick,
  output logic [PHASE_W-1:0] phase_q
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  // prescaler: counts 0..div, restarts when stopped
  always_ff @(posedge clk) begin
    if (rst || !run)      cnt_q <= '0;
    else if (cnt_q == div) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // accumulator wraps modulo 2**PHASE_W
  always_ff @(posedge clk) begin
    if (rst || !run) phase_q <= '0;
    else if (tick)   phase_q <= phase_q + step;
  end
endmodule

// File: rtl/tone_cos_rom.sv
module tone_cos_rom #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int  DEPTH = 1 << AW;
  localparam real AMP   = $itor((1 << (DW - 1)) - 1);
  localparam real TWO_PI = 6.283185307179586;

  logic [DW-1:0] rom [DEPTH];

  function automatic logic [DW-1:0] cos_entry(input int idx);
    real v;
    int  r;
    v = AMP * $cos(TWO_PI * $itor(idx) / $itor(DEPTH));
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    return DW'(r);
  endfunction

  // contents are computed once; the array maps onto a ROM resource
  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = cos_entry(i);
  end

  assign data = rom[addr];
endmodule

// File: rtl/tone_chan_post.sv
module tone_chan_post
  import tone_pkg::*;
(
  input  logic [SAMPLE_W-1:0] sample,
  input  chan_cfg_t           cfg,
  output logic [SAMPLE_W-1:0] code
);
  localparam logic [SAMPLE_W-1:0] MSB_MASK = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] LOW_MASK = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic signed [SAMPLE_W-1:0] shifted;
  logic        [SAMPLE_W-1:0] biased;

  always_comb begin
    shifted = $signed(sample) >>> cfg.scale;
    biased  = $unsigned(shifted) + cfg.offset;
    unique case (cfg.inv)
      INV_NONE: code = biased;
      INV_ALL:  code = ~biased;
      INV_MSB:  code = biased ^ MSB_MASK;
      INV_LOW:  code = biased ^ LOW_MASK;
      default:  code = biased;
    endcase
  end
endmodule

// File: rtl/dual_tone_dds.sv
module dual_tone_dds
  import tone_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int DIV_W   = 3,
  parameter int DATA_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [SAMPLE_W-1:0] dac0_code,
  output logic [SAMPLE_W-1:0] dac1_code
);
  localparam int NUM_CH = 2;
  localparam int LUT_AW = SAMPLE_W;

  logic [PHASE_W-1:0]  step_q;
  logic [DIV_W-1:0]    div_q;
  logic                run_q;
  chan_cfg_t           cfg_q  [NUM_CH];
  logic [SAMPLE_W-1:0] code_q [NUM_CH];
  logic                tick;
  logic [PHASE_W-1:0]  phase_q;
  logic [SAMPLE_W-1:0] lut_data;
  logic [SAMPLE_W-1:0] proc   [NUM_CH];
  logic [SAMPLE_W-1:0] out_q  [NUM_CH];

  // flat views for the bound checker
  logic       en_ch0, en_ch1;
  logic [1:0] inv_ch0, inv_ch1;
  assign en_ch0  = cfg_q[0].tone_en;
  assign en_ch1  = cfg_q[1].tone_en;
  assign inv_ch0 = cfg_q[0].inv;
  assign inv_ch1 = cfg_q[1].inv;

  tone_regs #(
    .PHASE_W(PHASE_W), .DIV_W(DIV_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .step_q(step_q), .div_q(div_q), .run_q(run_q), .cfg_q(cfg_q), .code_q(code_q)
  );

  tone_phase #(.PHASE_W(PHASE_W), .DIV_W(DIV_W)) u_phase (
    .clk(clk), .rst(rst), .run(run_q), .div(div_q), .step(step_q),
    .tick(tick), .phase_q(phase_q)
  );

  tone_cos_rom #(.AW(LUT_AW), .DW(SAMPLE_W)) u_rom (
    .addr(phase_q[PHASE_W-1 -: LUT_AW]),
    .data(lut_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    logic active;
    assign active = run_q && cfg_q[c].tone_en;

    tone_chan_post u_post (
      .sample(lut_data), .cfg(cfg_q[c]), .code(proc[c])
    );

    always_ff @(posedge clk) begin
      if (rst)          out_q[c] <= '0;
      else if (!active) out_q[c] <= code_q[c];
      else if (tick)    out_q[c] <= proc[c];
    end
  end

  assign dac0_code = out_q[0];
  assign dac1_code = out_q[1];
endmodule

// File: rtl/tone_checker.sv
module tone_checker #(
  parameter int PHASE_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               run_q,
  input logic               tick,
  input logic [PHASE_W-1:0] step_q,
  input logic [PHASE_W-1:0] phase_q,
  input logic               en_ch0,
  input logic               en_ch1,
  input logic [1:0]         inv_ch0,
  input logic [1:0]         inv_ch1,
  input logic [7:0]         code0,
  input logic [7:0]         code1,
  input logic [7:0]         out0,
  input logic [7:0]         out1
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst_d |-> (out0 == 8'd0 && out1 == 8'd0));

  assert_static_mux_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!(run_q && en_ch0)) |-> out0 == $past(code0));

  assert_phase_adv_R3: assert property (@(posedge clk) disable iff (rst)
    $past(tick) |-> phase_q == $past(phase_q + step_q));

  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (rst)
    $past(run_q && en_ch1 && !tick) |-> $stable(out1));

  assert_step_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    step_q != '0);

  assert_force_msb_inv_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(en_ch0) |-> inv_ch0 == 2'd2);

  assert_force_msb_inv1_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(en_ch1) |-> inv_ch1 == 2'd2);

  assert_phase_zero_idle_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!run_q) |-> phase_q == '0);
endmodule

bind dual_tone_dds tone_checker #(.PHASE_W(PHASE_W)) u_tone_checker (
  .clk(clk), .rst(rst), .run_q(run_q), .tick(tick), .step_q(step_q),
  .phase_q(phase_q), .en_ch0(en_ch0), .en_ch1(en_ch1), .inv_ch0(inv_ch0),
  .inv_ch1(inv_ch1), .code0(code_q[0]), .code1(code_q[1]),
  .out0(dac0_code), .out1(dac1_code)
);

// File: tb/test_dual_tone_dds.sv
`timescale 1ns/1ps
module test_dual_tone_dds;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  dac0_code, dac1_code;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_STEP = 3'd0, A_CTRL = 3'd1, A_CFG0 = 3'd2,
                         A_CFG1 = 3'd3, A_CODE0 = 3'd4, A_CODE1 = 3'd5;

  dual_tone_dds i_dual_tone_dds (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dac0_code(dac0_code), .dac1_code(dac1_code)
  );

  always #2.5 clk = ~clk;

  function automatic int cos_ref(input int idx);
    real v;
    v = 127.0 * $cos(6.283185307179586 * $itor(idx % 256) / 256.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  function automatic logic [7:0] post_ref(input int idx, input int sc, input int off, input int inv);
    int sh;
    logic [7:0] b;
    sh = cos_ref(idx) >>> sc;
    b  = 8'((sh + off) & 255);
    case (inv)
      1: return ~b;
      2: return b ^ 8'h80;
      3: return b ^ 8'h7F;
      default: return b;
    endcase
  endfunction

  function automatic logic [15:0] cfg_word(input int en, input int inv, input int sc, input int off);
    return {3'b000, 1'(en), 2'(inv), 2'(sc), 8'(off)};
  endfunction

  function automatic logic [15:0] ctrl_word(input int dv, input int run);
    return {12'd0, 1'(run), 3'(dv)};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string req);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // clocks between two successive arrivals of the peak code 0x7F on channel 0
  task automatic measure_period(output int period);
    int first = -1;
    logic [7:0] prev = dac0_code;
    period = -1;
    for (int c = 1; c < 3000; c++) begin
      @(negedge clk);
      if (dac0_code == 8'h7F && prev != 8'h7F) begin
        if (first < 0) first = c;
        else begin period = c - first; break; end
      end
      prev = dac0_code;
    end
  endtask

  task automatic t_reset();
    check(dac0_code, 8'h00, "R1 ch0 after reset");
    check(dac1_code, 8'h00, "R1 ch1 after reset");
  endtask

  task automatic t_static();
    reg_wr(A_CODE0, 16'h00A5);
    reg_wr(A_CODE1, 16'h003C);
    @(negedge clk);
    check(dac0_code, 8'hA5, "R2 ch0 static code");
    check(dac1_code, 8'h3C, "R2 ch1 static code");
    // tone enables set but run clear: still static
    reg_wr(A_CFG0, cfg_word(1, 0, 0, 0));
    reg_wr(A_CFG1, cfg_word(1, 0, 0, 0));
    @(negedge clk);
    check(dac0_code, 8'hA5, "R10 run clear keeps ch0 static");
    check(dac1_code, 8'h3C, "R10 run clear keeps ch1 static");
  endtask

  task automatic t_combos();
    int offs[3] = '{0, 128, 195};
    reg_wr(A_STEP, 16'h0B00);
    for (int sc = 0; sc < 4; sc++)
      for (int iv = 0; iv < 4; iv++)
        for (int o = 0; o < 3; o++) begin
          reg_wr(A_CTRL, ctrl_word(0, 0));
          reg_wr(A_CFG0, cfg_word(1, iv, sc, offs[o]));
          reg_wr(A_CFG0, cfg_word(1, iv, sc, offs[o]));
          reg_wr(A_CFG1, cfg_word(1, 3 - iv, 3 - sc, 255 - offs[o]));
          reg_wr(A_CFG1, cfg_word(1, 3 - iv, 3 - sc, 255 - offs[o]));
          reg_wr(A_CTRL, ctrl_word(0, 1));
          for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(dac0_code, post_ref(k * 11, sc, offs[o], iv), "R3 R6 R7 R8 ch0 sample");
            check(dac1_code, post_ref(k * 11, 3 - sc, 255 - offs[o], 3 - iv), "R3 R6 R7 R8 ch1 sample");
          end
        end
    reg_wr(A_CTRL, ctrl_word(0, 0));
  endtask

  task automatic t_invert_force();
    reg_wr(A_CTRL, ctrl_word(0, 0));
    reg_wr(A_STEP, 16'h0100);
    reg_wr(A_CFG0, cfg_word(0, 0, 0, 0));
    reg_wr(A_CFG0, cfg_word(1, 0, 0, 0));
    reg_wr(A_CTRL, ctrl_word(0, 1));
    @(negedge clk);
    check(dac0_code, post_ref(0, 0, 0, 2), "R9 enable forces MSB inversion");
    reg_wr(A_CFG0, cfg_word(1, 0, 0, 0));
    check(dac0_code, post_ref(1, 0, 0, 2), "R9 R11 rewrite not yet applied");
    @(negedge clk);
    check(dac0_code, post_ref(2, 0, 0, 0), "R9 rewrite with enable set takes field");
    reg_wr(A_CTRL, ctrl_word(0, 0));
  endtask

  task automatic t_gating();
    reg_wr(A_CODE0, 16'h0011);
    reg_wr(A_CODE1, 16'h005A);
    reg_wr(A_CFG1, cfg_word(0, 0, 0, 0));
    reg_wr(A_CFG0, cfg_word(1, 0, 0, 0));
    reg_wr(A_STEP, 16'h0100);
    reg_wr(A_CTRL, ctrl_word(0, 1));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(dac0_code, post_ref(k, 0, 0, 0), "R10 ch0 tone while ch1 off");
      check(dac1_code, 8'h5A, "R10 ch1 static while its tone off");
    end
    reg_wr(A_CTRL, ctrl_word(0, 0));
    @(negedge clk);
    check(dac0_code, 8'h11, "R10 run cleared returns ch0 to static");
    reg_wr(A_CTRL, ctrl_word(0, 1));
    @(negedge clk);
    check(dac0_code, post_ref(0, 0, 0, 0), "R10 restart at entry 0");
    reg_wr(A_CTRL, ctrl_word(0, 0));
  endtask

  task automatic t_period();
    int p;
    reg_wr(A_CFG0, cfg_word(1, 0, 0, 0));
    reg_wr(A_STEP, 16'h1000);
    reg_wr(A_CTRL, ctrl_word(2, 1));
    measure_period(p);
    check_int(p, 48, "R4 period div 2 step 0x1000");
    reg_wr(A_STEP, 16'h0000);
    measure_period(p);
    check_int(p, 48, "R5 zero step ignored");
    reg_wr(A_CTRL, ctrl_word(0, 0));
    reg_wr(A_STEP, 16'h4000);
    reg_wr(A_CTRL, ctrl_word(7, 1));
    measure_period(p);
    check_int(p, 32, "R4 period div 7 step 0x4000");
    reg_wr(A_CTRL, ctrl_word(0, 0));
  endtask

  task automatic t_collide();
    reg_wr(A_CFG0, cfg_word(1, 0, 0, 0));
    reg_wr(A_STEP, 16'h0100);
    reg_wr(A_CTRL, ctrl_word(0, 1));
    for (int k = 0; k < 5; k++) @(negedge clk);
    reg_wr(A_CFG0, cfg_word(1, 0, 1, 0));
    check(dac0_code, post_ref(5, 0, 0, 0), "R11 sample at write edge keeps old scale");
    @(negedge clk);
    check(dac0_code, post_ref(6, 1, 0, 0), "R11 R6 next sample uses new scale");
    reg_wr(A_CTRL, ctrl_word(0, 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog (all requirements): act=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_static();
    t_combos();
    t_invert_force();
    t_gating();
    t_period();
    t_collide();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule